// File: doc/BRIEF.md
# Microwire EEPROM host command controller

This block is the host side of a three-wire serial link to a 16-bit-word serial EEPROM with sixteen registers. A command comes in on a small request interface: a command code, a 4-bit register address and a 16-bit write word. The block then builds the serial frame and drives chip select, the serial clock and serial data out. It samples serial data in and returns the read word. When the command has finished it raises a one-cycle done pulse.

Every frame starts with a start bit, then a 2-bit operation code, then a 6-bit field, all sent MSB first. Two commands carry a data word after the field. A read clocks in a discarded zero bit and then the data word. Erase and write commands start a self-timed programming cycle inside the memory. For these the controller drops chip select at the end of the frame, waits a minimum low time, raises chip select again and polls serial data in until the memory reports ready. If ready does not arrive within a parameterised number of cycles, the command finishes with an error flag. The serial clock half-period, the minimum chip-select low time and the poll timeout are parameters.

Top module: `mw_eeprom_host`

## Requirements
- R1: Command codes on `req_cmd_i` are 0 read, 1 write, 2 erase, 3 write-enable, 4 write-disable, 5 erase-all and 6 write-all; code 7 is sent as write-disable. A frame is a 1 start bit, then a 2-bit operation code, then a 6-bit field, MSB first. Read uses operation 10, write uses 01 and erase uses 11, and each has the field 00 followed by the 4-bit address.
- R2: The four commands without an address use operation 00. Their field begins 11 for write-enable, 00 for write-disable, 10 for erase-all and 01 for write-all, and the low four field bits are sent as 0. Write-enable, write-disable and erase-all frames are exactly 9 clocks long.
- R3: Write and write-all frames append the 16-bit write word MSB first, for a total of 25 serial clocks.
- R4: A read frame lasts 26 serial clocks. `sdo_o` is 0 after the field. The bit sampled at the 10th rising edge is discarded. The bits at rising edges 11 to 26 become `rd_data_o` bits 15 down to 0, which are valid while `done_o` is high.
- R5: Within a frame, the serial clock is high for CLK_HALF cycles and low for CLK_HALF cycles, including the low phase before the first rising edge. `sdo_o` changes only while the serial clock is low, and the serial clock is never high while chip select is low.
- R6: After the last falling edge of an erase, write, erase-all or write-all frame, chip select goes low at that same edge with the serial clock low. It stays low for exactly CS_LOW_CYC cycles and then rises again. The block then samples `sdi_i` every cycle, and the first 1 ends the command with `err_o` low.
- R7: If `sdi_i` stays 0 for POLL_TIMEOUT poll cycles, chip select is high for exactly POLL_TIMEOUT cycles and the command ends with `err_o` high together with `done_o`. `err_o` is never high without `done_o`.
- R8: Chip select is low for at least CS_LOW_CYC cycles before every rise.
- R9: A request is accepted only while `req_ready_o` is high, and a request presented while a command is running is ignored. Each accepted command produces exactly one frame and exactly one `done_o` pulse of one cycle. Read, write-enable and write-disable end without a poll window.
- R10: Out of reset, chip select, the serial clock and `sdo_o` are low, `req_ready_o` is high and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Command request |
| req_ready_o | output | 1 | Block idle, request will be taken |
| req_cmd_i | input | 3 | Command code |
| req_addr_i | input | 4 | Register address |
| req_wdata_i | input | 16 | Word for write and write-all |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Ready poll timed out (with done) |
| rd_data_o | output | 16 | Word returned by a read |
| cs_o | output | 1 | Chip select to the memory |
| sclk_o | output | 1 | Serial clock to the memory |
| sdo_o | output | 1 | Serial data to the memory |
| sdi_i | input | 1 | Serial data / ready status from the memory |

## Verification
A wrong bit counter or shift register shows up within one frame. The captured frame length or header differs, or read data comes back shifted by one position when the dummy bit is mishandled. A stuck phase counter shows up within a few system cycles as a serial clock phase longer or shorter than CLK_HALF, or as data changing while the clock is high. A wrong gap or timeout counter shows up at the next programming command, as a chip-select low window or poll window of the wrong length. A state machine that skips the poll shows up as a done pulse that arrives before the memory is ready.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int unsigned HDR_W  = 9;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned TX_W   = HDR_W + DATA_W;
  localparam int unsigned LEN_W  = 5;
  localparam int unsigned RD_FIRST = HDR_W + 1;  // first bit index holding data

  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_ERASE = 3'd2,
    CMD_WEN   = 3'd3,
    CMD_WDS   = 3'd4,
    CMD_ERAL  = 3'd5,
    CMD_WRAL  = 3'd6
  } mw_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_SHIFT, ST_GAP, ST_POLL, ST_DONE
  } mw_state_e;

  function automatic logic [HDR_W-1:0] mw_header(input logic [2:0] cmd,
                                                 input logic [ADDR_W-1:0] addr);
    case (cmd)
      CMD_READ:  mw_header = {1'b1, 2'b10, 2'b00, addr};
      CMD_WRITE: mw_header = {1'b1, 2'b01, 2'b00, addr};
      CMD_ERASE: mw_header = {1'b1, 2'b11, 2'b00, addr};
      CMD_WEN:   mw_header = {1'b1, 2'b00, 6'b110000};
      CMD_ERAL:  mw_header = {1'b1, 2'b00, 6'b100000};
      CMD_WRAL:  mw_header = {1'b1, 2'b00, 6'b010000};
      default:   mw_header = {1'b1, 2'b00, 6'b000000};
    endcase
  endfunction

  function automatic logic mw_has_data(input logic [2:0] cmd);
    return (cmd == CMD_WRITE) || (cmd == CMD_WRAL);
  endfunction

  function automatic logic mw_is_prog(input logic [2:0] cmd);
    return (cmd == CMD_WRITE) || (cmd == CMD_ERASE) ||
           (cmd == CMD_ERAL)  || (cmd == CMD_WRAL);
  endfunction

  function automatic logic [LEN_W-1:0] mw_frame_len(input logic [2:0] cmd);
    if (cmd == CMD_READ)  return LEN_W'(HDR_W + 1 + DATA_W);
    if (mw_has_data(cmd)) return LEN_W'(HDR_W + DATA_W);
    return LEN_W'(HDR_W);
  endfunction
endpackage

// File: rtl/mw_sclk_gen.sv
module mw_sclk_gen #(
  parameter int unsigned HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(HALF + 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = en_i && (cnt_q == CW'(HALF - 1));
  assign rise_o = wrap && !sclk_o;
  assign fall_o = wrap && sclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_o <= !sclk_o;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mw_wait_timer.sv
module mw_wait_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  // expires in the LIMIT-th enabled cycle
  assign expire_o = en_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!en_i)     cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
  import mw_pkg::*;
#(
  parameter int unsigned CLK_HALF     = 4,
  parameter int unsigned CS_LOW_CYC   = 4,
  parameter int unsigned POLL_TIMEOUT = 5000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [2:0]  req_cmd_i,
  input  logic [3:0]  req_addr_i,
  input  logic [15:0] req_wdata_i,
  output logic        done_o,
  output logic        err_o,
  output logic [15:0] rd_data_o,
  output logic        cs_o,
  output logic        sclk_o,
  output logic        sdo_o,
  input  logic        sdi_i
);
  mw_state_e          state_q;
  logic [2:0]         cmd_q;
  logic [TX_W-1:0]    tx_q;
  logic [LEN_W-1:0]   bit_q;
  logic [DATA_W-1:0]  rx_q;
  logic               err_q;
  logic               rise, fall, gap_exp, poll_exp;
  logic               last_bit, accept;

  mw_sclk_gen #(.HALF(CLK_HALF)) i_sclk_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_SHIFT),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mw_wait_timer #(.LIMIT(CS_LOW_CYC)) i_gap_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     ((state_q == ST_LEAD) || (state_q == ST_GAP)),
    .expire_o (gap_exp)
  );

  mw_wait_timer #(.LIMIT(POLL_TIMEOUT)) i_poll_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (state_q == ST_POLL),
    .expire_o (poll_exp)
  );

  assign accept   = req_valid_i && (state_q == ST_IDLE);
  assign last_bit = (bit_q == mw_frame_len(cmd_q) - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_WDS;
      tx_q    <= '0;
      bit_q   <= '0;
      rx_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          cmd_q   <= req_cmd_i;
          tx_q    <= {mw_header(req_cmd_i, req_addr_i),
                      mw_has_data(req_cmd_i) ? req_wdata_i : 16'h0000};
          bit_q   <= '0;
          err_q   <= 1'b0;
          state_q <= ST_LEAD;
        end
        ST_LEAD: if (gap_exp) state_q <= ST_SHIFT;
        ST_SHIFT: begin
          // dummy bit sits at index HDR_W and is not captured
          if (rise && (cmd_q == CMD_READ) && (bit_q >= LEN_W'(RD_FIRST)))
            rx_q <= {rx_q[DATA_W-2:0], sdi_i};
          if (fall) begin
            tx_q <= {tx_q[TX_W-2:0], 1'b0};
            if (last_bit) state_q <= mw_is_prog(cmd_q) ? ST_GAP : ST_DONE;
            else          bit_q   <= bit_q + 1'b1;
          end
        end
        ST_GAP: if (gap_exp) state_q <= ST_POLL;
        ST_POLL: begin
          if (sdi_i) state_q <= ST_DONE;
          else if (poll_exp) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign cs_o        = (state_q == ST_SHIFT) || (state_q == ST_POLL);
  assign sdo_o       = (state_q == ST_SHIFT) && tx_q[TX_W-1];
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = (state_q == ST_DONE) && err_q;
  assign rd_data_o   = rx_q;
endmodule

// File: rtl/mw_eeprom_host_chk.sv
module mw_eeprom_host_chk #(
  parameter int unsigned CS_LOW_CYC = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic done_o,
  input logic err_o,
  input logic cs_o,
  input logic sclk_o,
  input logic sdo_o
);
  localparam int unsigned CW = $clog2(CS_LOW_CYC + 2);

  logic [CW-1:0] lo_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             lo_cnt_q <= '0;
    else if (cs_o)                           lo_cnt_q <= '0;
    else if (lo_cnt_q < CW'(CS_LOW_CYC))     lo_cnt_q <= lo_cnt_q + 1'b1;
  end

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_accept_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r7_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  a_r5_sdo_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o && $past(cs_o) && !$stable(sdo_o)) |-> !sclk_o);

  a_r5_sclk_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> cs_o);

  a_r6_cs_drop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> !sclk_o);

  a_r8_min_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_o) |-> (int'(lo_cnt_q) >= int'(CS_LOW_CYC)));
endmodule

bind mw_eeprom_host mw_eeprom_host_chk #(.CS_LOW_CYC(CS_LOW_CYC)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .cs_o        (cs_o),
  .sclk_o      (sclk_o),
  .sdo_o       (sdo_o)
);

// File: tb/test_mw_eeprom_host.sv
module test_mw_eeprom_host;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_P     = 2;
  localparam int TCS_P      = 3;
  localparam int TO_P       = 40;
  localparam int BUSY_P     = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_cmd = '0;
  logic [3:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic done, err;
  logic [15:0] rd_data;
  logic cs, sclk, sdo;
  logic sdi = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_host #(.CLK_HALF(HALF_P), .CS_LOW_CYC(TCS_P), .POLL_TIMEOUT(TO_P)) i_mw_eeprom_host (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_cmd_i(req_cmd), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .done_o(done), .err_o(err), .rd_data_o(rd_data),
    .cs_o(cs), .sclk_o(sclk), .sdo_o(sdo), .sdi_i(sdi));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [16];
  logic sk_q = 1'b0, cs_q = 1'b0;
  int nbits = 0, busy = 0, frames = 0, last_nbits = 0;
  logic [25:0] frame = '0, last_frame = '0;
  logic [8:0] hdr = '0;
  bit reading = 0, stuck = 0;

  always @(posedge clk) begin
    sk_q <= sclk;
    cs_q <= cs;
    if (busy > 0) busy--;
    if (!stuck && busy > BUSY_P) busy = 0;
    if (cs && !cs_q) begin nbits = 0; frame = '0; reading = 0; end
    if (!reading) sdi <= cs && (busy == 0);
    if (cs && sclk && !sk_q) begin
      frame = {frame[24:0], sdo};
      nbits++;
      if (nbits == 9) begin
        hdr = frame[8:0];
        reading = (frame[7:6] == 2'b10);
        if (reading) sdi <= 1'b0;
      end else if (reading && nbits >= 10 && nbits <= 25) begin
        sdi <= mem[hdr[3:0]][25-nbits];
      end
    end
    if (!cs && cs_q && nbits > 0) begin
      bit applied = 0;
      frames++;
      last_frame = frame;
      last_nbits = nbits;
      reading = 0;
      if (nbits == 9 && hdr[7:6] == 2'b11) begin mem[hdr[3:0]] = 16'hFFFF; applied = 1; end
      if (nbits == 25 && hdr[7:6] == 2'b01) begin mem[hdr[3:0]] = frame[15:0]; applied = 1; end
      if (nbits == 9 && hdr[7:4] == 4'b0010) begin
        for (int i = 0; i < 16; i++) mem[i] = 16'hFFFF;
        applied = 1;
      end
      if (nbits == 25 && hdr[7:4] == 4'b0001) begin
        for (int i = 0; i < 16; i++) mem[i] = frame[15:0];
        applied = 1;
      end
      if (applied) busy = stuck ? 1000000 : BUSY_P;
    end
  end

  // ---------------- port monitors ----------------
  int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0, min_lo = 1000;
  int sk_hi = 0, sk_lo = 0, bad_sk = 0, bad_sdo = 0, done_cnt = 0;
  logic sdo_prev = 1'b0, cs_prev = 1'b0;
  bit seen_hi = 0;

  always @(negedge clk) if (rst_n) begin
    if (done) done_cnt++;
    if (cs && cs_prev && sdo != sdo_prev && sclk) bad_sdo++;
    if (cs) begin
      if (lo_run > 0) begin
        last_lo = lo_run;
        if (seen_hi && lo_run < min_lo) min_lo = lo_run;
        lo_run = 0;
      end
      hi_run++;
      seen_hi = 1;
    end else begin
      if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
      lo_run++;
    end
    if (sclk) begin
      if (sk_lo > 0 && sk_lo != HALF_P) bad_sk++;
      sk_lo = 0;
      sk_hi++;
    end else begin
      if (sk_hi > 0 && sk_hi != HALF_P) bad_sk++;
      sk_hi = 0;
      if (cs) sk_lo++; else sk_lo = 0;
    end
    sdo_prev = sdo;
    cs_prev = cs;
  end

  // ---------------- command driver ----------------
  logic got_done, got_err;
  logic [15:0] got_rd;

  task automatic do_cmd(input logic [2:0] c, input logic [3:0] a, input logic [15:0] d);
    int n = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    got_done = done; got_err = err; got_rd = rd_data;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(cs == 0 && sclk == 0 && sdo == 0, "R10 serial pins low", {cs, sclk, sdo}, 0);
    chk(req_ready == 1 && done == 0, "R10 ready/done", {req_ready, done}, 2'b10);
  endtask

  task automatic t_no_addr(input logic [2:0] c, input logic [5:0] field, input string tag);
    int f0 = frames;
    int d0 = done_cnt;
    do_cmd(c, 4'hA, 16'hBEEF);
    chk(last_nbits == 9, {tag, " frame length"}, last_nbits, 9);
    chk(last_frame[8:0] == {1'b1, 2'b00, field}, {tag, " header"}, last_frame[8:0], {1'b1, 2'b00, field});
    chk(frames == f0 + 1 && done_cnt == d0 + 1, "R9 one frame one done", frames - f0, 1);
  endtask

  task automatic t_write(input logic [3:0] a, input logic [15:0] d);
    do_cmd(3'd1, a, d);
    chk(last_nbits == 25, "R3 write length", last_nbits, 25);
    chk(last_frame[24:0] == {1'b1, 2'b01, 2'b00, a, d}, "R1 R3 write frame",
        last_frame[24:0], {1'b1, 2'b01, 2'b00, a, d});
    chk(got_done && !got_err, "R6 write done ok", {got_done, got_err}, 2'b10);
    chk(last_lo == TCS_P, "R6 gap before poll", last_lo, TCS_P);
  endtask

  task automatic t_read(input logic [3:0] a, input logic [15:0] exp);
    do_cmd(3'd0, a, 16'h0);
    chk(last_nbits == 26, "R4 read length", last_nbits, 26);
    chk(last_frame[25:0] == {1'b1, 2'b10, 2'b00, a, 17'h0}, "R1 R4 read frame",
        last_frame[25:0], {1'b1, 2'b10, 2'b00, a, 17'h0});
    chk(got_rd == exp, "R4 read data", got_rd, exp);
  endtask

  task automatic t_erase(input logic [3:0] a);
    do_cmd(3'd2, a, 16'h0);
    chk(last_nbits == 9 && last_frame[8:0] == {1'b1, 2'b11, 2'b00, a}, "R1 erase frame",
        last_frame[8:0], {1'b1, 2'b11, 2'b00, a});
    chk(got_done && !got_err, "R6 erase done ok", {got_done, got_err}, 2'b10);
  endtask

  task automatic t_wral(input logic [15:0] d);
    do_cmd(3'd6, 4'h7, d);
    chk(last_nbits == 25 && last_frame[24:0] == {9'b1_00_010000, d}, "R2 R3 write-all frame",
        last_frame[24:0], {9'b1_00_010000, d});
    chk(got_done && !got_err, "R6 write-all done ok", {got_done, got_err}, 2'b10);
  endtask

  task automatic t_timeout;
    stuck = 1;
    do_cmd(3'd1, 4'h3, 16'h1111);
    chk(got_done && got_err, "R7 timeout err", {got_done, got_err}, 2'b11);
    chk(last_hi == TO_P, "R7 poll window length", last_hi, TO_P);
    stuck = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_ignore_busy;
    int f0 = frames;
    int d0 = done_cnt;
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 3'd3; req_addr = '0; req_wdata = '0;
    @(negedge clk);
    req_cmd = 3'd0;  // different request held while running
    repeat (10) @(negedge clk);
    chk(req_ready == 0, "R9 not ready while running", req_ready, 0);
    req_valid = 1'b0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk(frames == f0 + 1 && last_frame[8:0] == 9'b1_00_110000, "R9 held request ignored",
        frames - f0, 1);
    chk(done_cnt == d0 + 1, "R9 single done", done_cnt - d0, 1);
  endtask

  task automatic t_timing;
    chk(bad_sk == 0, "R5 serial clock phases", bad_sk, 0);
    chk(bad_sdo == 0, "R5 sdo change while clock high", bad_sdo, 0);
    chk(min_lo >= TCS_P, "R8 min chip select low", min_lo, TCS_P);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_no_addr(3'd3, 6'b110000, "R2 write-enable");
    t_write(4'h5, 16'hA5C3);
    t_read(4'h5, 16'hA5C3);
    t_write(4'hF, 16'h8001);
    t_read(4'hF, 16'h8001);
    t_erase(4'h9);
    t_read(4'h9, 16'hFFFF);
    t_wral(16'h1234);
    t_read(4'h0, 16'h1234);
    t_read(4'hF, 16'h1234);
    t_no_addr(3'd5, 6'b100000, "R2 erase-all");
    t_read(4'h5, 16'hFFFF);
    t_no_addr(3'd4, 6'b000000, "R2 write-disable");
    t_no_addr(3'd7, 6'b000000, "R1 code 7 as write-disable");
    t_timeout();
    t_ignore_busy();
    t_timing();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule